// File: doc/BRIEF.md
# Flash Command Sequence Controller

This block models the write-cycle command interpreter of a 16-bit-wide flash memory. A host sends write words (address plus data) and read requests. The controller watches the write words for multi-word unlock patterns at two fixed addresses. When a pattern completes, it runs one of these actions:

- program a word
- erase the whole array
- erase everything outside the boot region
- permanently lock the boot region
- enter or leave an identification mode

Program and erase run as timed internal operations against a behavioural storage array. Their durations are scaled down to clock-cycle parameters. While such an operation runs, `busy` is high and both request channels apply back-pressure.

Both host channels are valid/ready streams.

- **Write channel:** a word is consumed in a cycle where `wr_valid` and `wr_ready` are both high.
- **Read channel:** a request is consumed in a cycle where `rd_valid` and `rd_ready` are both high. The response is a single-cycle pulse on `rsp_valid` with `rsp_data` in the next cycle. The response has no back-pressure, so the host must always be able to take it.
- **Back-pressure:** both ready signals are low for the whole time `busy` is high. A host may hold valid with stable payload across that time.

The array holds `2**MEM_AW` words. Addresses are reduced to their low `MEM_AW` bits when selecting a word. The boot region is the array indices whose bits above `BOOT_AW-1` are all zero. A full-size part uses `MEM_AW=16` and `BOOT_AW=13`, which gives 64K words with an 8K boot region. The defaults are smaller so that the model stays cheap.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After reset, `busy` is low, both ready signals are high, `rsp_valid` is low, identification mode is off and the boot lock is clear.
- R2: The write sequence 5555h/AAh, 2AAAh/55h, 5555h/A0h, then any address with a data word programs that word. The stored value becomes old AND new. Addresses are matched on all 16 bits. Only data bits [7:0] are matched against key and command bytes; bits [15:8] are ignored.
- R3: A program keeps `busy` high for exactly `PROG_CYC` cycles, starting the cycle after the data word is accepted. The controller then returns to normal reads by itself.
- R4: The six-word sequence 5555h/AAh, 2AAAh/55h, 5555h/80h, 5555h/AAh, 2AAAh/55h, 5555h/10h erases the array. `busy` stays high for exactly `ERASE_CYC` cycles (`ERASE_CYC` must be at least `2**MEM_AW`). With the lock clear, every word reads FFFFh afterwards.
- R5: The same six-word sequence ending in 30h erases only indices outside the boot region. Boot words keep their value up to and including the last boot index.
- R6: The six-word sequence ending in 40h sets the boot lock without asserting `busy`. From then on, a program to a boot index changes nothing, while programs elsewhere still work.
- R7: With the lock set, the sequence ending in 10h leaves every boot word unchanged and sets all other words to FFFFh.
- R8: In identification mode, reads return fixed values by full address: 0000h gives 00DAh, 0001h gives 002Fh, 0002h gives 00FFh when locked or 00FEh when unlocked, and any other address gives 0000h. The mode is entered by 5555h/AAh, 2AAAh/55h, 5555h/90h.
- R9: Identification mode ends after either of two writes: the three-word sequence ending in 5555h/F0h, or a single write with data byte F0h at any address received while no sequence is in progress. After that, reads return array contents.
- R10: A write that does not match the expected next word of a sequence returns the interpreter to idle, and that write itself is discarded. A later complete sequence works normally.
- R11: While in identification mode, program, erase, lock and re-entry sequences are discarded: no `busy`, no array change, no lock change.
- R12: While `busy` is high, `wr_ready` and `rd_ready` are low. Every accepted read produces `rsp_valid` exactly one cycle later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Write word offered |
| wr_ready | output | 1 | Write word can be taken (low while busy) |
| wr_addr | input | 16 | Write word address |
| wr_data | input | 16 | Write word data |
| rd_valid | input | 1 | Read request offered |
| rd_ready | output | 1 | Read request can be taken (low while busy) |
| rd_addr | input | 16 | Read address |
| rsp_valid | output | 1 | Read response pulse, one cycle after acceptance |
| rsp_data | output | 16 | Read response data |
| busy | output | 1 | Internal program or erase running |

## Verification
The assertions rely on three assumptions about the environment:

- Commands that start an operation only arrive while the controller is idle. The ready signals enforce this, and the bench always waits for ready before raising valid.
- A read response is never stalled.
- The lock cannot change while an operation is in flight, because no write is accepted during `busy`.

The bench drives every input on the falling clock edge. It offers a read or write only after seeing the matching ready high, and it consumes each response in the cycle it appears.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

  localparam logic [15:0] UNLOCK_A = 16'h5555;
  localparam logic [15:0] UNLOCK_B = 16'h2AAA;

  localparam logic [7:0] KEY_FIRST  = 8'hAA;
  localparam logic [7:0] KEY_SECOND = 8'h55;
  localparam logic [7:0] CODE_PROG  = 8'hA0;
  localparam logic [7:0] CODE_ARM   = 8'h80;
  localparam logic [7:0] CODE_CHIP  = 8'h10;
  localparam logic [7:0] CODE_MAIN  = 8'h30;
  localparam logic [7:0] CODE_LOCK  = 8'h40;
  localparam logic [7:0] CODE_IDIN  = 8'h90;
  localparam logic [7:0] CODE_IDOUT = 8'hF0;

  localparam logic [15:0] IDV_MAKER  = 16'h00DA;
  localparam logic [15:0] IDV_PART   = 16'h002F;
  localparam logic [15:0] IDV_LOCKED = 16'h00FF;
  localparam logic [15:0] IDV_OPEN   = 16'h00FE;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_GOT1,
    SQ_GOT2,
    SQ_PDATA,
    SQ_ARM0,
    SQ_ARM1,
    SQ_ARM2
  } seq_state_e;

  typedef enum logic [2:0] {
    CMD_NONE,
    CMD_PROG,
    CMD_CHIP,
    CMD_MAIN,
    CMD_LOCK,
    CMD_ID_IN,
    CMD_ID_OUT
  } cmd_kind_e;

  typedef struct packed {
    cmd_kind_e   kind;
    logic [15:0] addr;
    logic [15:0] data;
  } cmd_t;

  typedef enum logic [1:0] {
    ENG_IDLE,
    ENG_PROG,
    ENG_ERASE
  } eng_state_e;

endpackage

// File: rtl/flash_word_store.sv
module flash_word_store #(
  parameter int AW = 11,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= cells[raddr];
  end
endmodule

// File: rtl/flash_seq_decoder.sv
module flash_seq_decoder
  import flash_cmd_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_fire,
  input  logic [15:0] wr_addr,
  input  logic [15:0] wr_data,
  input  logic        id_mode,
  output logic        cmd_valid,
  output cmd_t        cmd
);
  seq_state_e st_q, st_d;
  logic [7:0] code;
  logic       at_a, at_b;

  assign code = wr_data[7:0];
  assign at_a = (wr_addr == UNLOCK_A);
  assign at_b = (wr_addr == UNLOCK_B);

  always_comb begin
    st_d      = st_q;
    cmd_valid = 1'b0;
    cmd.kind  = CMD_NONE;
    cmd.addr  = wr_addr;
    cmd.data  = wr_data;
    if (wr_fire) begin
      unique case (st_q)
        SQ_IDLE: begin
          if (at_a && code == KEY_FIRST) begin
            st_d = SQ_GOT1;
          end else if (code == CODE_IDOUT && id_mode) begin
            cmd_valid = 1'b1;
            cmd.kind  = CMD_ID_OUT;
          end
        end
        SQ_GOT1: st_d = (at_b && code == KEY_SECOND) ? SQ_GOT2 : SQ_IDLE;
        SQ_GOT2: begin
          st_d = SQ_IDLE;
          if (at_a) begin
            if (code == CODE_IDOUT) begin
              if (id_mode) begin
                cmd_valid = 1'b1;
                cmd.kind  = CMD_ID_OUT;
              end
            end else if (!id_mode) begin
              if (code == CODE_PROG) st_d = SQ_PDATA;
              else if (code == CODE_ARM) st_d = SQ_ARM0;
              else if (code == CODE_IDIN) begin
                cmd_valid = 1'b1;
                cmd.kind  = CMD_ID_IN;
              end
            end
          end
        end
        SQ_PDATA: begin
          st_d      = SQ_IDLE;
          cmd_valid = 1'b1;
          cmd.kind  = CMD_PROG;
        end
        SQ_ARM0: st_d = (at_a && code == KEY_FIRST) ? SQ_ARM1 : SQ_IDLE;
        SQ_ARM1: st_d = (at_b && code == KEY_SECOND) ? SQ_ARM2 : SQ_IDLE;
        SQ_ARM2: begin
          st_d = SQ_IDLE;
          if (at_a) begin
            if (code == CODE_CHIP) begin
              cmd_valid = 1'b1;
              cmd.kind  = CMD_CHIP;
            end else if (code == CODE_MAIN) begin
              cmd_valid = 1'b1;
              cmd.kind  = CMD_MAIN;
            end else if (code == CODE_LOCK) begin
              cmd_valid = 1'b1;
              cmd.kind  = CMD_LOCK;
            end
          end
        end
        default: st_d = SQ_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st_q <= SQ_IDLE;
    else        st_q <= st_d;
  end

  // R10: every completed command leaves the interpreter at idle
  a_r10_idle_after_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> (st_q == SQ_IDLE));

  // R10: a write outside any sequence never jumps past the first key
  a_r10_start_only_key: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == SQ_IDLE) |=> (st_q == SQ_IDLE || st_q == SQ_GOT1));
endmodule

// File: rtl/flash_op_engine.sv
module flash_op_engine
  import flash_cmd_pkg::*;
#(
  parameter int MEM_AW    = 11,
  parameter int BOOT_AW   = 9,
  parameter int PROG_CYC  = 16,
  parameter int ERASE_CYC = 2200
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_prog,
  input  logic              start_erase,
  input  logic              prog_ok,
  input  logic              erase_boot_ok,
  input  logic [MEM_AW-1:0] cmd_addr,
  input  logic [15:0]       cmd_data,
  output logic              busy,
  output logic              mem_re,
  output logic [MEM_AW-1:0] mem_raddr,
  input  logic [15:0]       mem_rdata,
  output logic              mem_we,
  output logic [MEM_AW-1:0] mem_waddr,
  output logic [15:0]       mem_wdata
);
  localparam int DEPTH  = 1 << MEM_AW;
  localparam int MAXC   = (ERASE_CYC > DEPTH) ? ERASE_CYC : DEPTH;
  localparam int CNT_W  = $clog2(MAXC + 1);
  localparam logic [CNT_W-1:0] PROG_LAST  = CNT_W'(PROG_CYC - 1);
  localparam logic [CNT_W-1:0] ERASE_LAST = CNT_W'(ERASE_CYC - 1);
  localparam logic [CNT_W-1:0] SWEEP_END  = CNT_W'(DEPTH);

  eng_state_e        op_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [MEM_AW-1:0] addr_q;
  logic [15:0]       data_q;
  logic              ok_q;
  logic              boot_ok_q;
  logic [MEM_AW-1:0] sweep_idx;
  logic              sweep_in_boot;
  logic              at_last;

  assign busy          = (op_q != ENG_IDLE);
  assign sweep_idx     = cnt_q[MEM_AW-1:0];
  assign sweep_in_boot = (sweep_idx[MEM_AW-1:BOOT_AW] == '0);
  assign at_last       = (op_q == ENG_PROG) ? (cnt_q == PROG_LAST) : (cnt_q == ERASE_LAST);

  always_comb begin
    mem_re    = (op_q == ENG_PROG) && (cnt_q == '0);
    mem_raddr = addr_q;
    mem_we    = 1'b0;
    mem_waddr = addr_q;
    mem_wdata = mem_rdata & data_q;
    if (op_q == ENG_PROG) begin
      mem_we = ok_q && (cnt_q == CNT_W'(1));
    end else if (op_q == ENG_ERASE && cnt_q < SWEEP_END) begin
      mem_waddr = sweep_idx;
      mem_wdata = '1;
      mem_we    = boot_ok_q || !sweep_in_boot;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      op_q      <= ENG_IDLE;
      cnt_q     <= '0;
      addr_q    <= '0;
      data_q    <= '0;
      ok_q      <= 1'b0;
      boot_ok_q <= 1'b0;
    end else if (start_prog) begin
      op_q   <= ENG_PROG;
      cnt_q  <= '0;
      addr_q <= cmd_addr;
      data_q <= cmd_data;
      ok_q   <= prog_ok;
    end else if (start_erase) begin
      op_q      <= ENG_ERASE;
      cnt_q     <= '0;
      boot_ok_q <= erase_boot_ok;
    end else if (busy) begin
      if (at_last) op_q <= ENG_IDLE;
      else         cnt_q <= cnt_q + 1'b1;
    end
  end

  // R3: busy only rises in response to a start request
  a_r3_busy_needs_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start_prog || start_erase));

  // R12: no start is ever presented while an operation runs
  a_r12_start_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (start_prog || start_erase) |-> !busy);

  // R4: erase counter stays inside its window
  a_r4_erase_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    (op_q == ENG_ERASE) |-> (cnt_q <= ERASE_LAST));
endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
  import flash_cmd_pkg::*;
#(
  parameter int MEM_AW    = 11,
  parameter int BOOT_AW   = 9,
  parameter int PROG_CYC  = 16,
  parameter int ERASE_CYC = 2200
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_valid,
  output logic        wr_ready,
  input  logic [15:0] wr_addr,
  input  logic [15:0] wr_data,
  input  logic        rd_valid,
  output logic        rd_ready,
  input  logic [15:0] rd_addr,
  output logic        rsp_valid,
  output logic [15:0] rsp_data,
  output logic        busy
);
  logic              wr_fire, rd_fire;
  logic              cmd_valid;
  cmd_t              cmd;
  logic              lock_q, id_q;
  logic              start_prog, start_erase;
  logic              cmd_in_boot;
  logic              eng_re, mem_re, mem_we;
  logic [MEM_AW-1:0] eng_raddr, mem_raddr, mem_waddr;
  logic [15:0]       mem_rdata, mem_wdata;
  logic              rsp_id_q;
  logic [15:0]       rsp_addr_q;
  logic [15:0]       id_word;

  assign wr_ready = !busy;
  assign rd_ready = !busy;
  assign wr_fire  = wr_valid && wr_ready;
  assign rd_fire  = rd_valid && rd_ready;

  flash_seq_decoder u_dec (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_fire   (wr_fire),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .id_mode   (id_q),
    .cmd_valid (cmd_valid),
    .cmd       (cmd)
  );

  assign start_prog  = cmd_valid && (cmd.kind == CMD_PROG);
  assign start_erase = cmd_valid && (cmd.kind == CMD_CHIP || cmd.kind == CMD_MAIN);
  assign cmd_in_boot = (cmd.addr[MEM_AW-1:BOOT_AW] == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lock_q <= 1'b0;
      id_q   <= 1'b0;
    end else if (cmd_valid) begin
      if (cmd.kind == CMD_LOCK)   lock_q <= 1'b1;
      if (cmd.kind == CMD_ID_IN)  id_q   <= 1'b1;
      if (cmd.kind == CMD_ID_OUT) id_q   <= 1'b0;
    end
  end

  flash_op_engine #(
    .MEM_AW    (MEM_AW),
    .BOOT_AW   (BOOT_AW),
    .PROG_CYC  (PROG_CYC),
    .ERASE_CYC (ERASE_CYC)
  ) u_eng (
    .clk           (clk),
    .rst_n         (rst_n),
    .start_prog    (start_prog),
    .start_erase   (start_erase),
    .prog_ok       (!(lock_q && cmd_in_boot)),
    .erase_boot_ok ((cmd.kind == CMD_CHIP) && !lock_q),
    .cmd_addr      (cmd.addr[MEM_AW-1:0]),
    .cmd_data      (cmd.data),
    .busy          (busy),
    .mem_re        (eng_re),
    .mem_raddr     (eng_raddr),
    .mem_rdata     (mem_rdata),
    .mem_we        (mem_we),
    .mem_waddr     (mem_waddr),
    .mem_wdata     (mem_wdata)
  );

  assign mem_re    = busy ? eng_re : rd_fire;
  assign mem_raddr = busy ? eng_raddr : rd_addr[MEM_AW-1:0];

  flash_word_store #(.AW(MEM_AW), .DW(16)) u_store (
    .clk   (clk),
    .we    (mem_we),
    .waddr (mem_waddr),
    .wdata (mem_wdata),
    .re    (mem_re),
    .raddr (mem_raddr),
    .rdata (mem_rdata)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      rsp_id_q   <= 1'b0;
      rsp_addr_q <= '0;
    end else begin
      rsp_valid <= rd_fire;
      if (rd_fire) begin
        rsp_id_q   <= id_q;
        rsp_addr_q <= rd_addr;
      end
    end
  end

  always_comb begin
    unique case (rsp_addr_q)
      16'h0000: id_word = IDV_MAKER;
      16'h0001: id_word = IDV_PART;
      16'h0002: id_word = lock_q ? IDV_LOCKED : IDV_OPEN;
      default:  id_word = 16'h0000;
    endcase
  end

  assign rsp_data = rsp_id_q ? id_word : mem_rdata;

  // R6: once locked, no array write lands in the boot region
  a_r6_locked_boot_untouched: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_q && mem_we) |-> (mem_waddr[MEM_AW-1:BOOT_AW] != '0));

  // R11: in identification mode only the exit command can be produced
  a_r11_id_only_exit: assert property (@(posedge clk) disable iff (!rst_n)
    (id_q && cmd_valid) |-> (cmd.kind == CMD_ID_OUT));

  // R12: a response follows exactly one accepted request
  a_r12_rsp_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(rd_valid && rd_ready));

  // R6: the lock never clears once set
  a_r6_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    $past(lock_q) |-> lock_q);
endmodule

// File: tb/flash_cmd_ctrl_tb_top.sv
module flash_cmd_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int MEM_AW     = 8;
  localparam int BOOT_AW    = 6;
  localparam int PROG_CYC   = 6;
  localparam int ERASE_CYC  = 300;
  localparam int DEPTH      = 1 << MEM_AW;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_valid = 1'b0;
  logic        wr_ready;
  logic [15:0] wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        rd_valid = 1'b0;
  logic        rd_ready;
  logic [15:0] rd_addr = '0;
  logic        rsp_valid;
  logic [15:0] rsp_data;
  logic        busy;

  int checks = 0;
  int failures = 0;
  logic last_rsp_valid;

  always #(CLK_PERIOD / 2) clk = ~clk;

  flash_cmd_ctrl #(
    .MEM_AW(MEM_AW), .BOOT_AW(BOOT_AW), .PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC)
  ) dut_i (
    .clk(clk), .rst_n(rst_n),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .busy(busy)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [15:0] d);
    @(negedge clk);
    while (!wr_ready) @(negedge clk);
    wr_valid = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [15:0] d);
    @(negedge clk);
    while (!rd_ready) @(negedge clk);
    rd_valid = 1'b1; rd_addr = a;
    @(negedge clk);
    rd_valid = 1'b0;
    d = rsp_data;
    last_rsp_valid = rsp_valid;
  endtask

  task automatic wait_done(output int n);
    n = 0;
    while (busy) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic seq3(input logic [7:0] op);
    wr(16'h5555, 16'h00AA);
    wr(16'h2AAA, 16'h0055);
    wr(16'h5555, {8'h00, op});
  endtask

  task automatic seq6(input logic [7:0] op);
    seq3(8'h80);
    seq3(op);
  endtask

  task automatic prog(input logic [15:0] a, input logic [15:0] d);
    int n;
    seq3(8'hA0);
    wr(a, d);
    wait_done(n);
  endtask

  task automatic t_reset;
    logic [15:0] d;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 busy", busy, 0);
    chk("R1 wr_ready", wr_ready, 1);
    chk("R1 rd_ready", rd_ready, 1);
    chk("R1 rsp_valid", rsp_valid, 0);
    rd(16'h0000, d);
    chk("R12 rsp_valid after read", last_rsp_valid, 1);
    @(negedge clk);
    chk("R12 rsp single pulse", rsp_valid, 0);
  endtask

  task automatic t_chip_erase_open;
    int n, bad;
    logic [15:0] d;
    seq6(8'h10);
    chk("R4 busy after erase cmd", busy, 1);
    wait_done(n);
    chk("R4 erase busy length", n, ERASE_CYC);
    bad = 0;
    for (int i = 0; i < DEPTH; i++) begin
      rd(16'(i), d);
      if (d !== 16'hFFFF) bad++;
    end
    chk("R4 words not FFFF after erase", bad, 0);
  endtask

  task automatic t_id;
    logic [15:0] d;
    seq3(8'h90);
    chk("R8 id entry no busy", busy, 0);
    rd(16'h0000, d); chk("R8 maker code", d, 16'h00DA);
    rd(16'h0001, d); chk("R8 part code", d, 16'h002F);
    rd(16'h0002, d); chk("R1 R8 lock clear status", d, 16'h00FE);
    rd(16'h0003, d); chk("R8 other address", d, 16'h0000);
    seq3(8'hF0);
    rd(16'h0000, d); chk("R9 three-word exit", d, 16'hFFFF);
    seq3(8'h90);
    rd(16'h0001, d); chk("R8 re-entry", d, 16'h002F);
    wr(16'h1234, 16'h00F0);
    rd(16'h0001, d); chk("R9 single-word exit", d, 16'hFFFF);
  endtask

  task automatic t_program;
    int n;
    logic [15:0] d;
    wr(16'h5555, 16'h12AA);
    wr(16'h2AAA, 16'h3455);
    wr(16'h5555, 16'h56A0);
    wr(16'h0080, 16'hF0F0);
    chk("R12 wr_ready low while busy", wr_ready, 0);
    chk("R12 rd_ready low while busy", rd_ready, 0);
    wait_done(n);
    chk("R3 program busy length", n, PROG_CYC);
    rd(16'h0080, d); chk("R2 programmed word", d, 16'hF0F0);
    prog(16'h0080, 16'h3C3C);
    rd(16'h0080, d); chk("R2 program is AND", d, 16'h3030);
  endtask

  task automatic t_broken;
    logic [15:0] d;
    wr(16'h5555, 16'h00AA);
    wr(16'h2AAA, 16'h0055);
    wr(16'h2AAA, 16'h00A0);
    wr(16'h0080, 16'h0000);
    chk("R10 broken sequence no busy", busy, 0);
    rd(16'h0080, d); chk("R10 broken sequence no program", d, 16'h3030);
    wr(16'h5555, 16'h00AA);
    wr(16'h5555, 16'h0055);
    prog(16'h0081, 16'h1234);
    rd(16'h0081, d); chk("R10 recovery after break", d, 16'h1234);
  endtask

  task automatic t_main_erase;
    int n;
    logic [15:0] d;
    prog(16'h0010, 16'h00AA);
    prog(16'h003F, 16'h0000);
    prog(16'h0040, 16'h0000);
    seq6(8'h30);
    wait_done(n);
    chk("R5 main erase busy length", n, ERASE_CYC);
    rd(16'h0010, d); chk("R5 boot word kept", d, 16'h00AA);
    rd(16'h003F, d); chk("R5 last boot index kept", d, 16'h0000);
    rd(16'h0040, d); chk("R5 first main index erased", d, 16'hFFFF);
    rd(16'h0080, d); chk("R5 main word erased", d, 16'hFFFF);
  endtask

  task automatic t_id_ignores;
    logic [15:0] d;
    seq3(8'h90);
    seq3(8'hA0);
    wr(16'h0082, 16'h0000);
    chk("R11 program ignored in id", busy, 0);
    seq6(8'h10);
    chk("R11 erase ignored in id", busy, 0);
    seq6(8'h40);
    rd(16'h0002, d); chk("R11 lock ignored in id", d, 16'h00FE);
    wr(16'h0000, 16'h00F0);
    rd(16'h0082, d); chk("R11 array untouched", d, 16'hFFFF);
    rd(16'h0010, d); chk("R11 boot word untouched", d, 16'h00AA);
  endtask

  task automatic t_lock;
    int n;
    logic [15:0] d;
    seq6(8'h40);
    chk("R6 lock no busy", busy, 0);
    seq3(8'h90);
    rd(16'h0002, d); chk("R6 R8 lock status", d, 16'h00FF);
    wr(16'h0000, 16'h00F0);
    prog(16'h0010, 16'h0000);
    rd(16'h0010, d); chk("R6 locked boot program", d, 16'h00AA);
    prog(16'h0083, 16'h0F0F);
    rd(16'h0083, d); chk("R6 main program while locked", d, 16'h0F0F);
    seq6(8'h10);
    wait_done(n);
    chk("R7 erase busy length", n, ERASE_CYC);
    rd(16'h0010, d); chk("R7 boot kept by erase", d, 16'h00AA);
    rd(16'h003F, d); chk("R7 last boot index kept", d, 16'h0000);
    rd(16'h0040, d); chk("R7 main erased", d, 16'hFFFF);
    rd(16'h0083, d); chk("R7 main word erased", d, 16'hFFFF);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    t_reset();
    t_chip_erase_open();
    t_id();
    t_program();
    t_broken();
    t_main_erase();
    t_id_ignores();
    t_lock();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule